// File: doc/BRIEF.md
# Instruction-Cycle Enable Prescaler

This block runs on the oscillator clock and produces a one-clock enable pulse at the instruction-cycle rate. The rest of the core uses this pulse to advance once per instruction cycle. A three-bit ratio field selects how many oscillator clocks make up one instruction cycle: 1, 2, 4, 8 or 16. Two option inputs restrict that choice. When the noise-filter option is on, or when the internal high-speed RC oscillator is the clock source, the two fastest ratios are not allowed. A request for either of them is then raised to a ratio of 4.

The ratio actually in force is shown on a small output as its base-2 exponent, so the rest of the core can see what the options allowed. A new request is applied only when an instruction cycle ends. Because of this, no cycle is ever shortened or stretched by a change in the middle of a cycle. The block only produces an enable. It does not generate, switch or gate any clock.

Top module: `cpu_cycle_prescaler`

## Requirements
- R1: Ratio field codes 0, 1, 2, 3 and 4 select 1, 2, 4, 8 and 16 oscillator clocks per instruction cycle. `eff_shift` reports the ratio in force as its exponent: 0 for 1, 1 for 2, 2 for 4, 3 for 8 and 4 for 16.
- R2: Ratio field codes 5, 6 and 7 act as code 4, so the ratio is 16 and `eff_shift` is 4.
- R3: With `noise_filt_en` high, a request for ratio 1 or 2 becomes ratio 4 (`eff_shift` = 2). Larger ratios pass through unchanged.
- R4: With `int_rc_src` high, a request for ratio 1 or 2 becomes ratio 4 (`eff_shift` = 2). Larger ratios pass through unchanged.
- R5: `cyc_en` is high for exactly one oscillator clock at the end of each instruction cycle, and each cycle lasts exactly the effective ratio in clocks. At ratio 1, `cyc_en` is high on every clock.
- R6: A change of the request takes effect only on the clock that follows a `cyc_en` pulse. The cycle already in progress finishes at the old ratio.
- R7: While `rst_n` is low, `cyc_en` is low and `eff_shift` follows the current request. After `rst_n` rises, the first `cyc_en` pulse falls on the N-th clock, where N is the effective ratio.
- R8: `eff_shift` never exceeds 4. It is never below 2 for a cycle that began while either restricting option was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ratio_sel | input | 3 | Requested ratio code |
| noise_filt_en | input | 1 | Noise-filter option; forbids ratios 1 and 2 |
| int_rc_src | input | 1 | Internal high-speed RC selected; forbids ratios 1 and 2 |
| cyc_en | output | 1 | One-clock instruction-cycle enable |
| eff_shift | output | 3 | Exponent of the effective ratio in force |

## Verification
The state consists of a cycle counter and a latched exponent. A counter that is off by one shows as a gap between `cyc_en` pulses that differs from two to the power of `eff_shift`, and this appears within one instruction cycle, so within 16 clocks at most. A latched exponent that is wrong, or latched at the wrong moment, shows on `eff_shift` on the clock after the boundary. For a change in the middle of a cycle, it shows as a pulse that comes early or late in the cycle that should have finished at the old ratio.

// File: rtl/cpu_cycle_prescaler.sv
module cpu_cycle_prescaler #(
  parameter int SEL_W       = 3,
  parameter int MAX_SHIFT   = 4,
  parameter int FLOOR_SHIFT = 2,
  localparam int CNT_W      = MAX_SHIFT,
  localparam int SH_W       = $clog2(MAX_SHIFT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic             noise_filt_en,
  input  logic             int_rc_src,
  output logic             cyc_en,
  output logic [SH_W-1:0]  eff_shift
);

  logic [SH_W-1:0]  req_shift;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             hit;

  always_comb begin
    if (int'(ratio_sel) > MAX_SHIFT) req_shift = SH_W'(MAX_SHIFT);
    else                             req_shift = SH_W'(ratio_sel);
    if ((noise_filt_en || int_rc_src) && int'(req_shift) < FLOOR_SHIFT)
      req_shift = SH_W'(FLOOR_SHIFT);
  end

  assign last   = CNT_W'((32'd1 << eff_shift) - 32'd1);
  assign hit    = (cnt == last);
  assign cyc_en = rst_n & hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      eff_shift <= req_shift;
    end else if (hit) begin
      cnt       <= '0;
      eff_shift <= req_shift;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r8_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(eff_shift) <= MAX_SHIFT);

  a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && (noise_filt_en || int_rc_src)) |=> int'(eff_shift) >= FLOOR_SHIFT);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> $stable(eff_shift));

  a_r5_single: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en |=> (!cyc_en || eff_shift == '0));

  a_r2_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && int'(ratio_sel) > MAX_SHIFT) |=> int'(eff_shift) == MAX_SHIFT);

endmodule

// File: tb/cpu_cycle_prescaler_test.sv
module cpu_cycle_prescaler_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ratio_sel = 3'd0;
  logic       noise_filt_en = 1'b0;
  logic       int_rc_src = 1'b0;
  logic       cyc_en;
  logic [2:0] eff_shift;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  int m_cnt;
  int m_sh;
  int since_rst;

  always #2 clk = ~clk;

  cpu_cycle_prescaler uut (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel),
    .noise_filt_en(noise_filt_en), .int_rc_src(int_rc_src),
    .cyc_en(cyc_en), .eff_shift(eff_shift)
  );

  function automatic int want_shift(int sel, bit nf, bit irc);
    int s;
    s = (sel >= 5) ? 4 : sel;
    if ((nf || irc) && s < 2) s = 2;
    return s;
  endfunction

  function automatic string shift_tag(int sel, bit nf, bit irc);
    if (sel >= 5) return "R2";
    if (sel < 2 && nf) return "R3";
    if (sel < 2 && irc) return "R4";
    return "R1";
  endfunction

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(int sel, bit nf, bit irc);
    @(negedge clk);
    rst_n = 1'b0;
    ratio_sel = 3'(sel); noise_filt_en = nf; int_rc_src = irc;
    @(negedge clk);
    @(negedge clk);
    #1;
    check("R7", int'(cyc_en), 0);
    check(shift_tag(sel, nf, irc), int'(eff_shift), want_shift(sel, nf, irc));
    @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0;
    m_sh = want_shift(sel, nf, irc);
    since_rst = 0;
  endtask

  task automatic run(int sel, bit nf, bit irc, int cycles, string en_tag);
    int exp_en;
    ratio_sel = 3'(sel); noise_filt_en = nf; int_rc_src = irc;
    for (int k = 0; k < cycles; k++) begin
      #1;
      exp_en = (m_cnt == (1 << m_sh) - 1) ? 1 : 0;
      check((since_rst < 16 && exp_en == 1) ? "R7" : en_tag, int'(cyc_en), exp_en);
      check("R8", int'(eff_shift), m_sh);
      if (exp_en == 1) begin
        m_cnt = 0;
        m_sh = want_shift(sel, nf, irc);
        since_rst = 16;
      end else begin
        m_cnt++;
      end
      since_rst++;
      @(negedge clk);
    end
  endtask

  initial begin
    for (int c = 0; c < 32; c++) begin
      do_reset(c % 8, c[3], c[4]);
      run(c % 8, c[3], c[4], 40, "R5");
      #1;
      check(shift_tag(c % 8, c[3], c[4]), int'(eff_shift), want_shift(c % 8, c[3], c[4]));
      @(negedge clk);
      m_cnt++;
      if (m_cnt == (1 << m_sh)) m_cnt = 0;
      since_rst = 16;
    end
    do_reset(0, 1'b0, 1'b0);
    for (int s = 0; s < 96; s++) begin
      int c;
      c = (s * 7 + 3) % 32;
      run(c % 8, c[3], c[4], 3 + (s % 5), "R6");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule